// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host processor a two-register path into the configuration space of devices on a parallel, PCI-style bus. The host first writes an address/command word that names a bus, device, function and dword register and carries an enable flag. It then reads or writes a data window. Each data-window access becomes one configuration cycle on a simple request/acknowledge target interface. Byte enables let the host write a single byte, a halfword or a full dword. A third register holds a sticky flag that records target error responses.

The control sequencer has four states. In IDLE it waits for a host access. An access to the data window while the enable flag is set takes the transition IDLE->ISSUE. Every other access takes IDLE->RESP at once. In ISSUE the target request is held high, and the transition ISSUE->RESP follows the acknowledge. RESP raises host ready for one cycle. From there, RESP->IDLE is taken if the host has already dropped its select, and RESP->RELEASE if it has not. In RELEASE the sequencer waits, and RELEASE->IDLE follows once select goes low. A new access therefore starts only after select has been released.

Top module: `cfg_access_port`

## Requirements
- R1: The address/command register sits at byte offset 0x28. It reads back the value last written, with bits 1:0 always reading zero. Only the byte lanes whose host byte enable is set are updated. It resets to zero.
- R2: An access to the data window at offset 0x2C reaches the target only when bit 31 of the address/command register is set.
- R3: During a target request, the bus number comes from bits 23:16 of the address/command register. The device number comes from bits 15:11, the function number from bits 10:8, and the dword register number from bits 7:2.
- R4: A data-window write with byte enables 4'b1111 forwards all 32 data bits with those enables.
- R5: A sub-word data-window write forwards the host byte enables unchanged, so only the chosen lanes are written. Examples are 4'b0100 for a byte at offset 0x2E and 4'b1100 for a halfword at 0x2E.
- R6: A data-window read requests all four lanes (byte enables 4'b1111) and returns the full target dword.
- R7: While the enable bit is clear, a data-window read returns 32'hFFFF_FFFF and a data-window write is dropped without any target request.
- R8: Host ready stays low until the target acknowledges. It then goes high for exactly one cycle. A data-window access completes on the second host-side cycle after the acknowledge is raised. A local register access completes one cycle after it starts.
- R9: A target acknowledge together with an error completes the access and sets bit 0 of the status register at offset 0x30. An errored read returns 32'hFFFF_FFFF. The flag stays set until the host writes a 1 to bit 0 with byte enable 0 set; writing a 0 leaves it set.
- R10: An access to any other offset reads zero, changes no state and completes without a target request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access request, held until ready |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte offset |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with ready |
| host_ready | output | 1 | One-cycle completion pulse |
| tgt_req | output | 1 | Configuration cycle request |
| tgt_we | output | 1 | Configuration write (1) or read (0) |
| tgt_bus | output | 8 | Bus number |
| tgt_dev | output | 5 | Device number |
| tgt_fn | output | 3 | Function number |
| tgt_reg | output | 6 | Dword register number |
| tgt_be | output | 4 | Byte enables of the cycle |
| tgt_wdata | output | 32 | Write data of the cycle |
| tgt_ack | input | 1 | Target response |
| tgt_err | input | 1 | Error qualifier with the response |
| tgt_rdata | input | 32 | Target read data with the response |

## Verification
If the latched address/command word is corrupted, the next target request shows the wrong bus, device, function or register number. A read-back of offset 0x28 exposes the same fault within two cycles. A sequencer stuck in the wrong state shows up either as a ready pulse of the wrong length or as a request made while the enable bit is clear. A stuck state can also make host ready arrive too early or never. The bench counts exact completion cycles for each acknowledge latency, so any of these faults appears on the access that triggers it. A lost or self-clearing error flag is exposed by the status read that follows an errored access.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int unsigned CW      = 32;
    localparam int unsigned LANES   = CW / 8;
    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned BUS_LSB = 16;
    localparam int unsigned BUS_W   = 8;
    localparam int unsigned DEV_LSB = 11;
    localparam int unsigned DEV_W   = 5;
    localparam int unsigned FN_LSB  = 8;
    localparam int unsigned FN_W    = 3;
    localparam int unsigned REG_LSB = 2;
    localparam int unsigned REG_W   = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_RELEASE
    } cfg_state_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ADDR,
        KIND_DATA,
        KIND_STAT
    } cfg_kind_e;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfgp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_OFS = 'h28,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h2C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h30
) (
    input  logic [ADDR_W-1:0] host_addr,
    output cfg_kind_e         kind
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = host_addr[ADDR_W-1:2];

    always_comb begin
        if (widx == ADDR_OFS[ADDR_W-1:2])      kind = KIND_ADDR;
        else if (widx == DATA_OFS[ADDR_W-1:2]) kind = KIND_DATA;
        else if (widx == STAT_OFS[ADDR_W-1:2]) kind = KIND_STAT;
        else                                   kind = KIND_NONE;
    end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfgp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LANES-1:0]   be,
    input  logic [CW-1:0]      wdata,
    output logic [CW-1:0]      word_q,
    output logic               cfg_en,
    output logic [BUS_W-1:0]   f_bus,
    output logic [DEV_W-1:0]   f_dev,
    output logic [FN_W-1:0]    f_fn,
    output logic [REG_W-1:0]   f_reg
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_d;
        if (g == 0) begin : g_low
            assign lane_d = wdata[7:0] & 8'hFC;
        end else begin : g_hi
            assign lane_d = wdata[g*8 +: 8];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g*8 +: 8] <= 8'h00;
            else if (wr_en && be[g])
                word_q[g*8 +: 8] <= lane_d;
        end
    end

    assign cfg_en = word_q[EN_BIT];
    assign f_bus  = word_q[BUS_LSB +: BUS_W];
    assign f_dev  = word_q[DEV_LSB +: DEV_W];
    assign f_fn   = word_q[FN_LSB  +: FN_W];
    assign f_reg  = word_q[REG_LSB +: REG_W];
endmodule

// File: rtl/cfg_err_flag.sv
module cfg_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end
endmodule

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_we,
    input  logic [LANES-1:0] host_be,
    input  logic [CW-1:0]    host_wdata,
    input  cfg_kind_e        kind,
    input  logic             cfg_en,
    input  logic [CW-1:0]    addr_word,
    input  logic             err_q,
    input  logic             tgt_ack,
    input  logic             tgt_err,
    input  logic [CW-1:0]    tgt_rdata,
    output logic             tgt_req,
    output logic             tgt_we,
    output logic [LANES-1:0] tgt_be,
    output logic [CW-1:0]    tgt_wdata,
    output logic             host_ready,
    output logic [CW-1:0]    host_rdata,
    output logic             addr_wr,
    output logic             err_set,
    output logic             err_clr
);
    localparam logic [CW-1:0]    ALL_ONES  = {CW{1'b1}};
    localparam logic [LANES-1:0] FULL_LANE = {LANES{1'b1}};

    cfg_state_e state_q, state_d;
    logic             launch, go_tgt;
    logic             we_q;
    logic [LANES-1:0] be_q;
    logic [CW-1:0]    wdata_q, rdata_q, local_rd;

    assign launch = (state_q == ST_IDLE) && host_sel;
    assign go_tgt = launch && (kind == KIND_DATA) && cfg_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_tgt)      state_d = ST_ISSUE;
                else if (launch) state_d = ST_RESP;
            end
            ST_ISSUE:   if (tgt_ack) state_d = ST_RESP;
            ST_RESP:    state_d = host_sel ? ST_RELEASE : ST_IDLE;
            ST_RELEASE: if (!host_sel) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tgt_req    = (state_q == ST_ISSUE);
        host_ready = (state_q == ST_RESP);
        addr_wr    = launch && host_we && (kind == KIND_ADDR);
        err_clr    = launch && host_we && (kind == KIND_STAT)
                     && host_be[0] && host_wdata[0];
        err_set    = (state_q == ST_ISSUE) && tgt_ack && tgt_err;
        tgt_we     = we_q;
        tgt_be     = we_q ? be_q : FULL_LANE;
        tgt_wdata  = wdata_q;
        host_rdata = rdata_q;
    end

    // read value of a locally completed access
    always_comb begin
        local_rd = '0;
        if (!host_we) begin
            unique case (kind)
                KIND_ADDR: local_rd = addr_word;
                KIND_STAT: local_rd = {{(CW-1){1'b0}}, err_q};
                KIND_DATA: local_rd = ALL_ONES;
                default:   local_rd = '0;
            endcase
        end
    end

    // captured access data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (launch) begin
            we_q    <= host_we;
            be_q    <= host_be;
            wdata_q <= host_wdata;
            rdata_q <= local_rd;
        end else if ((state_q == ST_ISSUE) && tgt_ack && !we_q) begin
            rdata_q <= tgt_err ? ALL_ONES : tgt_rdata;
        end
    end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfgp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_OFS = 'h28,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h2C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [7:0]        tgt_bus,
    output logic [4:0]        tgt_dev,
    output logic [2:0]        tgt_fn,
    output logic [5:0]        tgt_reg,
    output logic [3:0]        tgt_be,
    output logic [31:0]       tgt_wdata,
    input  logic              tgt_ack,
    input  logic              tgt_err,
    input  logic [31:0]       tgt_rdata
);
    cfg_kind_e   kind;
    logic [CW-1:0] addr_word;
    logic        cfg_en, addr_wr, err_set, err_clr, err_q;

    cfg_decode #(
        .ADDR_W(ADDR_W), .ADDR_OFS(ADDR_OFS),
        .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
    ) u_dec (
        .host_addr(host_addr),
        .kind     (kind)
    );

    cfg_addr_reg u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (addr_wr),
        .be    (host_be),
        .wdata (host_wdata),
        .word_q(addr_word),
        .cfg_en(cfg_en),
        .f_bus (tgt_bus),
        .f_dev (tgt_dev),
        .f_fn  (tgt_fn),
        .f_reg (tgt_reg)
    );

    cfg_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (err_clr),
        .flag_q(err_q)
    );

    cfg_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .host_we   (host_we),
        .host_be   (host_be),
        .host_wdata(host_wdata),
        .kind      (kind),
        .cfg_en    (cfg_en),
        .addr_word (addr_word),
        .err_q     (err_q),
        .tgt_ack   (tgt_ack),
        .tgt_err   (tgt_err),
        .tgt_rdata (tgt_rdata),
        .tgt_req   (tgt_req),
        .tgt_we    (tgt_we),
        .tgt_be    (tgt_be),
        .tgt_wdata (tgt_wdata),
        .host_ready(host_ready),
        .host_rdata(host_rdata),
        .addr_wr   (addr_wr),
        .err_set   (err_set),
        .err_clr   (err_clr)
    );
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_ready,
    input logic        tgt_req,
    input logic        tgt_we,
    input logic        tgt_ack,
    input logic        tgt_err,
    input logic [3:0]  tgt_be,
    input logic [31:0] tgt_wdata,
    input logic [7:0]  tgt_bus,
    input logic        cfg_en,
    input logic        err_q,
    input logic        err_clr
);
    assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> cfg_en);

    assert_read_full_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_we) |-> (tgt_be == 4'hF));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_wdata)
                                   && $stable(tgt_be) && $stable(tgt_bus)));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_no_ready_in_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> !host_ready);

    assert_err_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && tgt_ack && tgt_err) |=> err_q);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
endmodule

bind cfg_access_port cfg_access_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ready(host_ready),
    .tgt_req   (tgt_req),
    .tgt_we    (tgt_we),
    .tgt_ack   (tgt_ack),
    .tgt_err   (tgt_err),
    .tgt_be    (tgt_be),
    .tgt_wdata (tgt_wdata),
    .tgt_bus   (tgt_bus),
    .cfg_en    (cfg_en),
    .err_q     (err_q),
    .err_clr   (err_clr)
);

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        tgt_req, tgt_we;
    logic [7:0]  tgt_bus;
    logic [4:0]  tgt_dev;
    logic [2:0]  tgt_fn;
    logic [5:0]  tgt_reg;
    logic [3:0]  tgt_be;
    logic [31:0] tgt_wdata;
    logic        tgt_ack = 1'b0, tgt_err = 1'b0;
    logic [31:0] tgt_rdata = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat = 0, lat_cnt = 0;
    bit inject_err = 1'b0;
    bit model_en = 1'b0;
    bit prev_req = 1'b0;
    logic [58:0] exp_q[$];
    logic [31:0] mem[logic [21:0]];

    cfg_access_port u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // target responder with its own configuration memory
    always @(negedge clk) begin
        if (tgt_ack) begin
            tgt_ack <= 1'b0;
            tgt_err <= 1'b0;
        end else if (tgt_req) begin
            if (lat_cnt == lat) begin
                logic [21:0] key;
                logic [31:0] cur;
                key = {tgt_bus, tgt_dev, tgt_fn, tgt_reg};
                cur = mem.exists(key) ? mem[key] : 32'h0;
                lat_cnt = 0;
                tgt_ack <= 1'b1;
                tgt_err <= inject_err;
                if (tgt_we && !inject_err) begin
                    for (int b = 0; b < 4; b++)
                        if (tgt_be[b]) cur[b*8 +: 8] = tgt_wdata[b*8 +: 8];
                    mem[key] = cur;
                end
                tgt_rdata <= cur;
            end else begin
                lat_cnt++;
            end
        end
    end

    // per-clock monitor against the expected request list
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_req && !model_en) begin
                n_chk++; n_fail++;
                $display("FAIL R2/R7 actual=req expected=no request");
            end
            if (tgt_req && !prev_req) begin
                logic [58:0] got;
                got = {tgt_we, tgt_bus, tgt_dev, tgt_fn, tgt_reg, tgt_be, tgt_we ? tgt_wdata : 32'h0};
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2 actual=%h expected=none", got);
                end else begin
                    logic [58:0] e;
                    e = exp_q.pop_front();
                    n_chk++;
                    if (got !== e) begin
                        n_fail++;
                        $display("FAIL R3/R4/R5/R6 actual=%h expected=%h", got, e);
                    end
                end
            end
            prev_req = tgt_req;
        end
    end

    // one host access; returns read data and completion cycle count
    task automatic access(input bit we, input logic [7:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int waits);
        @(negedge clk);
        host_sel = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; host_be = be;
        if (addr == 8'h28 && we && be[3]) model_en = wd[31];
        waits = 0;
        rd = 'x;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            waits++;
            if (host_ready) begin
                rd = host_rdata;
                break;
            end
        end
        host_sel = 1'b0;
    endtask

    function automatic logic [58:0] expd(bit we, logic [31:0] aw, logic [3:0] be, logic [31:0] wd);
        return {we, aw[23:16], aw[15:11], aw[10:8], aw[7:2], we ? be : 4'hF, we ? wd : 32'h0};
    endfunction

    initial begin
        logic [31:0] rd;
        int w;
        logic [31:0] aw;
        repeat (3) @(negedge clk);
        // reset state
        check("R8 reset ready", {31'b0, host_ready}, 32'h0);
        check("R8 reset req", {31'b0, tgt_req}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 8'h28, 0, 4'hF, rd, w);
        check("R1 reset addr reg", rd, 32'h0);
        check("R8 local completes in one cycle", w, 1);
        access(1'b0, 8'h30, 0, 4'hF, rd, w);
        check("R9 reset status", rd, 32'h0);

        // disabled window
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R7 disabled read ones", rd, 32'hFFFF_FFFF);
        access(1'b1, 8'h28, 32'h0012_3A57, 4'hF, rd, w);
        access(1'b1, 8'h2C, 32'hDEAD_BEEF, 4'hF, rd, w);
        check("R7 disabled write local completion", w, 1);

        // address register read-back and lane writes
        access(1'b0, 8'h28, 0, 4'hF, rd, w);
        check("R1 readback low bits zero", rd, 32'h0012_3A54);
        access(1'b1, 8'h28, 32'hFFFF_C3FF, 4'b0010, rd, w);
        access(1'b0, 8'h28, 0, 4'hF, rd, w);
        check("R1 lane write", rd, 32'h0012_C354);

        // enable, verify dropped write never landed
        aw = 32'h8012_5A4C;
        access(1'b1, 8'h28, aw, 4'hF, rd, w);
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R7 dropped write left target unchanged", rd, 32'h0);
        check("R8 read waits lat0", w, 2);

        // word, byte and halfword writes
        exp_q.push_back(expd(1'b1, aw, 4'hF, 32'hA1B2_C3D4));
        access(1'b1, 8'h2C, 32'hA1B2_C3D4, 4'hF, rd, w);
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R4 word write readback", rd, 32'hA1B2_C3D4);
        exp_q.push_back(expd(1'b1, aw, 4'b0100, 32'h005E_0000));
        access(1'b1, 8'h2E, 32'h005E_0000, 4'b0100, rd, w);
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R5 byte write lane2", rd, 32'hA15E_C3D4);
        exp_q.push_back(expd(1'b1, aw, 4'b1100, 32'h7788_0000));
        access(1'b1, 8'h2E, 32'h7788_0000, 4'b1100, rd, w);
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R5 halfword write upper", rd, 32'h7788_C3D4);
        check("R6 full dword read", rd, 32'h7788_C3D4);

        // distinct key and latencies
        aw = 32'h80FF_F7FC;
        access(1'b1, 8'h28, aw, 4'hF, rd, w);
        for (int l = 0; l < 4; l++) begin
            lat = l;
            exp_q.push_back(expd(1'b1, aw, 4'hF, 32'h1000 + l));
            access(1'b1, 8'h2C, 32'h1000 + l, 4'hF, rd, w);
            check("R8 write stall cycles", w, l + 2);
            exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
            access(1'b0, 8'h2C, 0, 4'hF, rd, w);
            check("R3 separate key readback", rd, 32'h1000 + l);
        end
        lat = 1;

        // error path
        inject_err = 1'b1;
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        check("R9 errored read ones", rd, 32'hFFFF_FFFF);
        inject_err = 1'b0;
        exp_q.push_back(expd(1'b0, aw, 4'hF, 0));
        access(1'b0, 8'h2C, 0, 4'hF, rd, w);
        access(1'b0, 8'h30, 0, 4'hF, rd, w);
        check("R9 sticky after good access", rd, 32'h1);
        access(1'b1, 8'h30, 32'h0, 4'hF, rd, w);
        access(1'b0, 8'h30, 0, 4'hF, rd, w);
        check("R9 write zero keeps flag", rd, 32'h1);
        access(1'b1, 8'h30, 32'h1, 4'hF, rd, w);
        access(1'b0, 8'h30, 0, 4'hF, rd, w);
        check("R9 write one clears", rd, 32'h0);

        // unmapped offset
        access(1'b1, 8'h10, 32'hFFFF_FFFF, 4'hF, rd, w);
        check("R10 unmapped write local", w, 1);
        access(1'b0, 8'h10, 0, 4'hF, rd, w);
        check("R10 unmapped read zero", rd, 32'h0);
        access(1'b0, 8'h28, 0, 4'hF, rd, w);
        check("R10 no state change", rd, aw);

        repeat (3) @(negedge clk);
        check("R2 expected requests consumed", exp_q.size(), 0);
        finish_run();
    end
endmodule